// File: doc/BRIEF.md
# Eight-Bit Bus Processor Core

This block is a small eight-bit processor. All transfers between its registers pass over one internal byte-wide bus. It holds two working registers (A, B), an ALU result register (O), a three-bit flag register, an instruction pointer, a memory pointer (M), an instruction latch and an immediate latch (VAL). It also holds a 256-byte RAM and a sequencer that spends a fixed six clock steps on every instruction. Step 0 fetches the opcode at IP. Step 1 fetches the immediate for two-byte instructions. Step 2 executes. Steps 3 to 5 are idle.

Software is loaded by writing the RAM through a preload port while reset is held low. Three instructions talk to the outside through a single control input. A display instruction drives a register onto an output with a valid flag. A read instruction latches an input byte. A halt instruction simply waits. In all three cases the sequencer holds in its execute step until the control input is seen high on a clock edge.

Top module: `bytecpu_core`

## Requirements
- R1: Every instruction, one byte or two, occupies exactly six clock cycles when it does not stall. The execute step is the third of the six.
- R2: Each opcode or immediate byte is read from RAM at IP, and IP then advances by one, wrapping from 0xFF to 0x00.
- R3: While `rst_n` is low, all registers and the step counter clear to zero, `ext_valid` and `wait_ctl` stay low, and each cycle with `pre_we` high writes `pre_data` to RAM at `pre_addr`.
- R4: The 2-bit source code selects the register driven onto the bus: 00 A, 01 B, 10 O, 11 VAL. MOV is 0001ssdd. STORE is 001000ss. DISP is 001100ss.
- R5: The 2-bit destination code selects the register written from the bus: 00 A, 01 B, 10 IP, 11 M. FETCH is 001001dd, LOAD is 001010dd and READ is 001101dd. Writing IP redirects execution.
- R6: LOAD, SAVE (0x2C), JMP (0x40), JLT (0x41) and JNZ (0x42) are two bytes long, and their second byte is held in VAL.
- R7: STORE writes the source register to RAM at M. SAVE writes VAL to RAM at M. FETCH reads RAM at M. INCM (0x2D) adds one to M and DECM (0x2E) subtracts one, both modulo 256.
- R8: JMP always loads IP from VAL. JLT does so only when the LT flag is set, and JNZ only when the NZ flag is set. Otherwise execution falls through.
- R9: Opcodes 111xxxxx write O and the flags, and the low five bits select the operation. The codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment A, 5 NAND, 6 shift left, 7 shift left through carry, 8 shift right, 9 shift right through carry. Carry is the carry out, the borrow, or the bit shifted out. LT is bit 7 of the result and NZ is set when the result is non-zero.
- R10: DISP, READ and HLT (0x2F) raise `wait_ctl` and freeze the step counter in the execute step until `ctl_pulse` is high at a clock edge. During that time DISP holds `ext_valid` high with a steady `ext_out`. READ writes `ext_in` to its destination on that edge.
- R11: Any opcode not listed above (for example 0x00 or 0x80) changes nothing but IP and the instruction latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also enables preload |
| pre_we | input | 1 | Preload write enable, honoured only in reset |
| pre_addr | input | 8 | Preload RAM address |
| pre_data | input | 8 | Preload RAM data |
| ext_in | input | 8 | External byte taken by READ |
| ctl_pulse | input | 1 | Control handshake that releases a stall |
| ext_out | output | 8 | Register value shown by DISP, zero otherwise |
| ext_valid | output | 1 | High while DISP is waiting for the handshake |
| wait_ctl | output | 1 | High while any stalling instruction waits |

## Verification
The properties check the sequencer on every cycle. The step counter stays below six and wraps from the last step to step 0. IP advances by one after each opcode fetch. The step counter freezes while a stall is unacknowledged, and DISP keeps `ext_out` and `ext_valid` steady until the handshake. Only the bench program can show the data results: the ALU arithmetic and flags, the source and destination decoding, RAM traffic through M, jumps taken and not taken, the IP wrap, and no-op opcodes. Each result is displayed and compared in order against values computed from the requirements, and the cycle distance between handshakes shows the six-step rule across one- and two-byte instructions.

// File: rtl/bytecpu_pkg.sv
// Shared types for the byte processor: ALU operation codes and flag record.
// Assumes an 8-bit machine word; the codes follow the ALU opcode low bits.
package bytecpu_pkg;

    typedef enum logic [4:0] {
        ALU_ADD  = 5'd0,
        ALU_ADDC = 5'd1,
        ALU_SUB  = 5'd2,
        ALU_SUBB = 5'd3,
        ALU_INC  = 5'd4,
        ALU_NAND = 5'd5,
        ALU_SHL  = 5'd6,
        ALU_SHLC = 5'd7,
        ALU_SHR  = 5'd8,
        ALU_SHRC = 5'd9
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic lt;
        logic nz;
    } flags_t;

endpackage

// File: rtl/bytecpu_alu.sv
// Combinational ALU. Takes A, B, the incoming carry and a 5-bit select.
// Produces a result and fresh flags. Unknown selects pass A with carry clear.
module bytecpu_alu
    import bytecpu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic [4:0]    sel,
    output logic [DW-1:0] y,
    output flags_t        fl
);
    logic [DW:0] wide;
    logic        cout;

    // Purpose: compute the result and carry for the selected operation.
    always_comb begin
        wide = '0;
        cout = 1'b0;
        y    = a;
        unique case (alu_op_e'(sel))
            ALU_ADD:  begin wide = {1'b0, a} + {1'b0, b};                  y = wide[DW-1:0]; cout = wide[DW]; end
            ALU_ADDC: begin wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin}; y = wide[DW-1:0]; cout = wide[DW]; end
            ALU_SUB:  begin wide = {1'b0, a} - {1'b0, b};                  y = wide[DW-1:0]; cout = wide[DW]; end
            ALU_SUBB: begin wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin}; y = wide[DW-1:0]; cout = wide[DW]; end
            ALU_INC:  begin wide = {1'b0, a} + {{DW{1'b0}}, 1'b1};        y = wide[DW-1:0]; cout = wide[DW]; end
            ALU_NAND: begin y = ~(a & b); end
            ALU_SHL:  begin y = {a[DW-2:0], 1'b0}; cout = a[DW-1]; end
            ALU_SHLC: begin y = {a[DW-2:0], cin};  cout = a[DW-1]; end
            ALU_SHR:  begin y = {1'b0, a[DW-1:1]}; cout = a[0]; end
            ALU_SHRC: begin y = {cin, a[DW-1:1]};  cout = a[0]; end
            default:  begin y = a; cout = 1'b0; end
        endcase
    end

    // Purpose: derive the flag record from the result.
    always_comb begin
        fl.carry = cout;
        fl.lt    = y[DW-1];
        fl.nz    = |y;
    end
endmodule

// File: rtl/bytecpu_ram.sv
// Byte RAM with one synchronous write port and two combinational read ports.
// One read port serves instruction fetch, the other serves M-addressed data.
// Contents are not cleared by reset.
module bytecpu_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_i,
    input  logic [AW-1:0] raddr_d,
    output logic [DW-1:0] rdata_d
);
    logic [DW-1:0] mem [DEPTH];

    // Purpose: store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: present both read ports without delay.
    always_comb begin
        rdata_i = mem[raddr_i];
        rdata_d = mem[raddr_d];
    end
endmodule

// File: rtl/bytecpu_stepper.sv
// Step counter for the fixed-length instruction cycle.
// It counts 0..STEPS-1 and wraps, and it holds its value while hold is high.
module bytecpu_stepper #(
    parameter int unsigned STEPS = 6,
    localparam int unsigned SW = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    output logic [SW-1:0] step
);
    // Purpose: advance or freeze the step, wrapping at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)                       step <= '0;
        else if (hold)                    step <= step;
        else if (step == SW'(STEPS - 1))  step <= '0;
        else                              step <= step + 1'b1;
    end
endmodule

// File: rtl/bytecpu_core.sv
// Eight-bit bus processor core. Step 0 fetches the opcode, step 1 fetches an
// optional immediate, step 2 executes, and steps 3..STEPS-1 are idle.
// DISP/READ/HLT freeze in the execute step until ctl_pulse. Assumes address
// width equals data width, so IP and M can be loaded from the bus.
module bytecpu_core
    import bytecpu_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned STEPS = 6,
    parameter int unsigned EXEC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_we,
    input  logic [DW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic [DW-1:0] ext_in,
    input  logic          ctl_pulse,
    output logic [DW-1:0] ext_out,
    output logic          ext_valid,
    output logic          wait_ctl
);
    localparam int unsigned AW = DW;
    localparam int unsigned SW = $clog2(STEPS);

    logic [DW-1:0] a_q, b_q, o_q, val_q, int_q;
    logic [AW-1:0] ip_q, m_q;
    flags_t        fl_q;
    logic [SW-1:0] step;
    logic [DW-1:0] rd_ip, rd_m, src_val, dst_val, alu_y;
    flags_t        alu_fl;
    logic [1:0]    src_code, dst_code;
    logic is_mov, is_store, is_fetch, is_load, is_save, is_incm, is_decm;
    logic is_hlt, is_disp, is_read, is_jmp, is_jlt, is_jnz, is_alu;
    logic two_byte, dst_we, jump_take, in_exec, hold;
    logic ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;

    bytecpu_stepper #(.STEPS(STEPS)) u_step (
        .clk(clk), .rst_n(rst_n), .hold(hold), .step(step)
    );

    bytecpu_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_i(ip_q), .rdata_i(rd_ip), .raddr_d(m_q), .rdata_d(rd_m)
    );

    bytecpu_alu #(.DW(DW)) u_alu (
        .a(a_q), .b(b_q), .cin(fl_q.carry), .sel(int_q[4:0]), .y(alu_y), .fl(alu_fl)
    );

    // Purpose: decode the latched opcode into instruction strobes.
    always_comb begin
        is_mov   = int_q[7:4] == 4'b0001;
        is_store = int_q[7:2] == 6'b001000;
        is_fetch = int_q[7:2] == 6'b001001;
        is_load  = int_q[7:2] == 6'b001010;
        is_save  = int_q == 8'h2C;
        is_incm  = int_q == 8'h2D;
        is_decm  = int_q == 8'h2E;
        is_hlt   = int_q == 8'h2F;
        is_disp  = int_q[7:2] == 6'b001100;
        is_read  = int_q[7:2] == 6'b001101;
        is_jmp   = int_q == 8'h40;
        is_jlt   = int_q == 8'h41;
        is_jnz   = int_q == 8'h42;
        is_alu   = int_q[7:5] == 3'b111;
        two_byte = is_load | is_save | is_jmp | is_jlt | is_jnz;
    end

    // Purpose: select bus source and destination value and the stall status.
    always_comb begin
        src_code = is_mov ? int_q[3:2] : int_q[1:0];
        dst_code = int_q[1:0];
        unique case (src_code)
            2'b00:   src_val = a_q;
            2'b01:   src_val = b_q;
            2'b10:   src_val = o_q;
            default: src_val = val_q;
        endcase
        if (is_load)       dst_val = val_q;
        else if (is_fetch) dst_val = rd_m;
        else if (is_read)  dst_val = ext_in;
        else               dst_val = src_val;
        dst_we    = is_mov | is_load | is_fetch | is_read;
        jump_take = is_jmp | (is_jlt & fl_q.lt) | (is_jnz & fl_q.nz);
        in_exec   = step == SW'(EXEC);
        wait_ctl  = in_exec & (is_disp | is_read | is_hlt);
        hold      = wait_ctl & ~ctl_pulse;
        ext_valid = wait_ctl & is_disp;
        ext_out   = ext_valid ? src_val : '0;
    end

    // Purpose: route preload writes in reset, else STORE/SAVE writes at M.
    always_comb begin
        ram_we    = rst_n ? (in_exec & (is_store | is_save)) : pre_we;
        ram_waddr = rst_n ? m_q : pre_addr;
        ram_wdata = !rst_n ? pre_data : (is_save ? val_q : src_val);
    end

    // Purpose: fetch, immediate latch and execute updates of the registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; o_q <= '0; val_q <= '0; int_q <= '0;
            ip_q <= '0; m_q <= '0; fl_q <= '0;
        end else if (step == '0) begin
            int_q <= rd_ip;
            ip_q  <= ip_q + 1'b1;
        end else if (step == SW'(1) && two_byte) begin
            val_q <= rd_ip;
            ip_q  <= ip_q + 1'b1;
        end else if (in_exec && !hold) begin
            if (is_alu) begin
                o_q  <= alu_y;
                fl_q <= alu_fl;
            end
            if (is_incm) m_q <= m_q + 1'b1;
            if (is_decm) m_q <= m_q - 1'b1;
            if (jump_take) ip_q <= val_q;
            if (dst_we) begin
                unique case (dst_code)
                    2'b00:   a_q  <= dst_val;
                    2'b01:   b_q  <= dst_val;
                    2'b10:   ip_q <= dst_val;
                    default: m_q  <= dst_val;
                endcase
            end
        end
    end
endmodule

// File: rtl/bytecpu_checker.sv
// Cycle properties of the sequencer and the stall handshake.
// Bound to every bytecpu_core instance and observes its ports and state.
module bytecpu_checker #(
    parameter int unsigned STEPS = 6,
    parameter int unsigned SW    = 3,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] step,
    input logic [AW-1:0] ip,
    input logic          wait_ctl,
    input logic          ctl_pulse,
    input logic          ext_valid,
    input logic [DW-1:0] ext_out
);
    // R1: the step counter never leaves its range
    p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step < SW'(STEPS));

    // R1: after the last step comes step 0
    p_step_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == SW'(STEPS - 1)) |=> (step == '0));

    // R2: the opcode fetch advances IP by one, modulo 256
    p_ip_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> (ip == AW'($past(ip) + 1'b1)));

    // R10: an unacknowledged stall freezes the step counter
    p_stall_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_ctl && !ctl_pulse) |=> $stable(step));

    // R10: DISP keeps its value and valid flag until the handshake
    p_disp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ctl_pulse) |=> (ext_valid && $stable(ext_out)));
endmodule

bind bytecpu_core bytecpu_checker #(.STEPS(STEPS), .SW(SW), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .ip(ip_q), .wait_ctl(wait_ctl),
    .ctl_pulse(ctl_pulse), .ext_valid(ext_valid), .ext_out(ext_out)
);

// File: tb/tb_bytecpu_core.sv
`timescale 1ns/1ps
// Scoreboard bench: a program is preloaded, the expected DISP values and the
// expected cycle gaps are queued, and a monitor compares and acknowledges.
module tb_bytecpu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    logic [7:0] ext_in = 8'hA7;
    logic       ctl_pulse = 1'b0;
    logic [7:0] ext_out;
    logic       ext_valid, wait_ctl;

    int tests = 0, fails = 0, cyc = 0, last_ack = 0, quiet_stalls = 0;
    bit running = 1'b0, done = 1'b0;

    typedef struct { logic [7:0] val; int gap; string tag; } exp_t;
    exp_t sb[$];
    logic [7:0] prog [256];

    bytecpu_core dut (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .ext_in(ext_in), .ctl_pulse(ctl_pulse),
        .ext_out(ext_out), .ext_valid(ext_valid), .wait_ctl(wait_ctl)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v, input int gap, input string tag);
        exp_t e;
        e.val = v; e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each DISP, acknowledge every stall, track gaps (R1, R10)
    always @(negedge clk) begin
        if (running && !done) begin
            if (ctl_pulse) ctl_pulse = 1'b0;
            else if (wait_ctl) begin
                if (ext_valid) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(ext_out == e.val, e.tag, ext_out, e.val);
                    if (e.gap != 0) chk(cyc - last_ack == e.gap, {"R1 gap before ", e.tag}, cyc - last_ack, e.gap);
                    if (sb.size() == 0) done = 1'b1;
                end else quiet_stalls++;
                last_ack = cyc;
                ctl_pulse = 1'b1;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        // program image (address: bytes)
        prog[8'h00] = 8'h30;                       // DISP A
        prog[8'h01] = 8'h28; prog[8'h02] = 8'h3C;  // LOAD A,3C
        prog[8'h03] = 8'h29; prog[8'h04] = 8'hC5;  // LOAD B,C5
        prog[8'h05] = 8'hE0; prog[8'h06] = 8'h32;  // ADD ; DISP O
        prog[8'h07] = 8'hE1; prog[8'h08] = 8'h32;  // ADDC ; DISP O
        prog[8'h09] = 8'hE2; prog[8'h0A] = 8'hE3; prog[8'h0B] = 8'h32; // SUB SUBB DISP
        prog[8'h0C] = 8'hE5; prog[8'h0D] = 8'h32;  // NAND ; DISP O
        prog[8'h0E] = 8'h14;                       // MOV B->A
        prog[8'h0F] = 8'hE6; prog[8'h10] = 8'hE7; prog[8'h11] = 8'h32; // SHL SHLC DISP
        prog[8'h12] = 8'hE8; prog[8'h13] = 8'hE9; prog[8'h14] = 8'h32; // SHR SHRC DISP
        prog[8'h15] = 8'hE4; prog[8'h16] = 8'h32;  // INC ; DISP O
        prog[8'h17] = 8'h41; prog[8'h18] = 8'h1C;  // JLT 1C (taken)
        prog[8'h19] = 8'h30;                       // skipped DISP A
        prog[8'h1C] = 8'h42; prog[8'h1D] = 8'h20;  // JNZ 20 (taken)
        prog[8'h1E] = 8'h30; prog[8'h1F] = 8'h30;  // skipped
        prog[8'h20] = 8'h28; prog[8'h21] = 8'hFF;  // LOAD A,FF
        prog[8'h22] = 8'hE4;                       // INC -> 00
        prog[8'h23] = 8'h41; prog[8'h24] = 8'h29;  // JLT 29 (not taken)
        prog[8'h25] = 8'h42; prog[8'h26] = 8'h29;  // JNZ 29 (not taken)
        prog[8'h27] = 8'h30;                       // DISP A
        prog[8'h28] = 8'h80;                       // undefined opcode
        prog[8'h29] = 8'h33;                       // DISP VAL
        prog[8'h2A] = 8'h2B; prog[8'h2B] = 8'h80;  // LOAD M,80
        prog[8'h2C] = 8'h2C; prog[8'h2D] = 8'h5D;  // SAVE 5D
        prog[8'h2E] = 8'h2D;                       // INCM
        prog[8'h2F] = 8'h21;                       // STORE B
        prog[8'h30] = 8'h2E;                       // DECM
        prog[8'h31] = 8'h24; prog[8'h32] = 8'h30;  // FETCH A ; DISP A
        prog[8'h33] = 8'h2D;                       // INCM
        prog[8'h34] = 8'h25; prog[8'h35] = 8'h31;  // FETCH B ; DISP B
        prog[8'h36] = 8'h35; prog[8'h37] = 8'h31;  // READ B ; DISP B
        prog[8'h38] = 8'h2F;                       // HLT
        prog[8'h39] = 8'h28; prog[8'h3A] = 8'h50;  // LOAD A,50
        prog[8'h3B] = 8'h12;                       // MOV A->IP
        prog[8'h3C] = 8'h30;                       // skipped
        prog[8'h50] = 8'h11; prog[8'h51] = 8'h31;  // MOV A->B ; DISP B
        prog[8'h52] = 8'h40; prog[8'h53] = 8'hFE;  // JMP FE
        prog[8'hFE] = 8'h28; prog[8'hFF] = 8'h77;  // LOAD A,77 then IP wraps

        // expected results, computed from the requirements
        push(8'h00, 0,  "R3 reset A");
        push(8'h01, 24, "R9 add 3C+C5");
        push(8'h02, 12, "R9 add with carry");
        push(8'h76, 18, "R9 subtract with borrow");
        push(8'hFB, 12, "R9 nand");
        push(8'h8B, 24, "R9 shift left through carry (R5 MOV)");
        push(8'hE2, 18, "R9 shift right through carry");
        push(8'hC6, 12, "R9 increment (R4 source O)");
        push(8'hFF, 42, "R8 jumps taken then not taken");
        push(8'h29, 12, "R6 VAL holds immediate, R11 no-op");
        push(8'h5D, 42, "R7 SAVE/FETCH at M");
        push(8'hC5, 18, "R7 STORE/INCM/DECM");
        push(8'hA7, 6,  "R10 READ latches ext_in");
        push(8'h50, 24, "R5 destination IP after HLT");
        push(8'h77, 18, "R2 IP wrap via JMP");

        // preload during reset (R3)
        repeat (2) @(negedge clk);
        chk(ext_valid == 1'b0, "R3 ext_valid low in reset", ext_valid, 0);
        chk(wait_ctl == 1'b0, "R3 wait_ctl low in reset", wait_ctl, 0);
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1; pre_addr = 8'(i); pre_data = prog[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        last_ack = cyc;
        running = 1'b1;

        fork
            wait (done);
            begin
                repeat (5000) @(negedge clk);
                chk(1'b0, "watchdog expired", sb.size(), 0);
            end
        join_any
        disable fork;
        @(negedge clk);
        chk(quiet_stalls == 2, "R10 READ and HLT stalls acknowledged", quiet_stalls, 2);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule